// File: doc/BRIEF.md
# Search Branch Step Sequencer

This block runs one branch decision of a bus ROM search on a single-wire bus. A start strobe arrives with a requested branch direction. The block then asks a bit-level slot engine for two single-bit read slots. The first returns the addressed ID bit and the second returns its complement. The block decides which way the search goes and asks the engine for one single-bit write slot that sends the chosen direction back onto the bus. It finishes by presenting a 3-bit result code with a one-cycle done strobe.

All line timing lives in the slot engine. The sequencer only exchanges request and acknowledge with it. Each slot request is guarded by a cycle counter, so a stuck engine aborts the step instead of hanging it. A search loop above this block calls it once per bit position and keeps its own discrepancy bookkeeping.

Top module: `ow_branch_step`

## Requirements
- R1: A step issues slots strictly in this order: the ID-bit read, then the complement read (both with `slotWrite`=0), then at most one write (`slotWrite`=1). The write is always the third slot.
- R2: If both sampled bits are 1, no device answered. The result is 3'b011 and no write slot is requested.
- R3: If both sampled bits are 0, the requested direction is written. The result is 3'b100 for direction 1 and 3'b000 for direction 0. Bit 2 of the result is the written direction, bit 1 is the complement bit and bit 0 is the ID bit.
- R4: If exactly one sampled bit is 1, the written direction equals the ID bit, whatever was requested. The result is 3'b101 when the ID bit is 1 and 3'b010 when it is 0.
- R5: Only bit 0 of `slotRdData` is taken as the sampled bit. The upper bits have no effect on the result or the written bit.
- R6: If a slot request is not acknowledged within `TIMEOUT_CYC` cycles, the request drops after exactly `TIMEOUT_CYC` cycles and no further slot is requested. `done` pulses and the result is 3'b011. An acknowledge in the last allowed cycle is still accepted.
- R7: `startReq` is ignored while `busy` is high, including the cycle in which `done` is high. A new direction offered then does not change the running step.
- R8: A slot request stays high until it is acknowledged or times out. `done` is high for exactly one cycle, one cycle after the final acknowledge or abort.
- R9: After reset the block is idle: `busy`, `slotReq` and `done` are low and `result` reads 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a step (honoured only when idle) |
| dirReq | input | 1 | Branch direction requested for a discrepancy |
| slotReq | output | 1 | Slot request to the slot engine |
| slotWrite | output | 1 | 1 = write slot, 0 = read slot |
| slotWrBit | output | 1 | Bit to send in a write slot |
| slotAck | input | 1 | One-cycle slot completion from the slot engine |
| slotRdData | input | RD_W | Read slot data, bit 0 significant |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle end-of-step strobe |
| result | output | 3 | Result code {direction, complement, ID} |

## Verification
The hardest cases to reach are the abort paths. A missing acknowledge must be timed to a chosen slot: the first read, or the write after a discrepancy. The bench's slot-engine model withholds the acknowledge for a selected slot index. It then counts how many cycles the request stays high and checks that no later slot is issued. A second hard case is a start strobe that overlaps the step or its done cycle. This is driven with the opposite direction so that an accepted restart would show up in the result or in a second busy period.

// File: rtl/ow_step_pkg.sv
package ow_step_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_CMP,
    ST_WR,
    ST_FIN
  } stepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStep;  // latch direction, preset result to "none"
    logic capId;    // sample ID bit
    logic capCmp;   // sample complement bit, fix direction
    logic loadRes;  // publish result code
    logic cntClr;   // restart slot timeout counter
    logic cntInc;   // advance slot timeout counter
  } stepCtl_t;

  localparam logic [2:0] RES_NONE = 3'b011;

endpackage

// File: rtl/ow_step_dp.sv
module ow_step_dp
  import ow_step_pkg::*;
#(
  parameter int RD_W        = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  stepCtl_t        ctl,
  input  logic            dirReq,
  input  logic [RD_W-1:0] slotRdData,
  output logic            tmoHit,
  output logic            noSlave,
  output logic            wrBit,
  output logic [2:0]      result
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             rdBit;
  logic             dirReg;
  logic             idBit;
  logic             cmpBit;
  logic             dirSel;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       resReg;

  assign rdBit = slotRdData[0];

  generate
    if (RD_W > 1) begin : g_hi
      logic unusedRdHi;
      assign unusedRdHi = ^slotRdData[RD_W-1:1];
    end
  endgenerate

  // slot timeout counter
  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc) cnt <= cnt + 1'b1;
  end

  assign tmoHit = (cnt == CNT_LAST);

  // bit capture and direction choice
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= 1'b0;
      idBit  <= 1'b0;
      cmpBit <= 1'b0;
      dirSel <= 1'b0;
    end else begin
      if (ctl.clrStep) dirReg <= dirReq;
      if (ctl.capId)   idBit  <= rdBit;
      if (ctl.capCmp) begin
        cmpBit <= rdBit;
        dirSel <= (idBit ^ rdBit) ? idBit : dirReg;
      end
    end
  end

  // both read slots came back high: nobody on the bus
  assign noSlave = idBit & rdBit;
  assign wrBit   = dirSel;

  always_ff @(posedge clk) begin
    if (!rstN)            resReg <= RES_NONE;
    else if (ctl.clrStep) resReg <= RES_NONE;
    else if (ctl.loadRes) resReg <= {dirSel, cmpBit, idBit};
  end

  assign result = resReg;

endmodule

// File: rtl/ow_step_ctrl.sv
module ow_step_ctrl
  import ow_step_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     slotAck,
  input  logic     tmoHit,
  input  logic     noSlave,
  output stepCtl_t ctl,
  output logic     slotReq,
  output logic     slotWrite,
  output logic     busy,
  output logic     done
);

  stepState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.clrStep = 1'b1;
          ctl.cntClr  = 1'b1;
          nextState   = ST_RD_ID;
        end
      end
      ST_RD_ID: begin
        if (slotAck) begin
          ctl.capId  = 1'b1;
          ctl.cntClr = 1'b1;
          nextState  = ST_RD_CMP;
        end else if (tmoHit) begin
          nextState  = ST_FIN;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_RD_CMP: begin
        if (slotAck) begin
          ctl.capCmp = 1'b1;
          ctl.cntClr = 1'b1;
          nextState  = noSlave ? ST_FIN : ST_WR;
        end else if (tmoHit) begin
          nextState  = ST_FIN;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_WR: begin
        if (slotAck) begin
          ctl.loadRes = 1'b1;
          nextState   = ST_FIN;
        end else if (tmoHit) begin
          nextState   = ST_FIN;
        end else begin
          ctl.cntInc  = 1'b1;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign slotReq   = (state == ST_RD_ID) || (state == ST_RD_CMP) || (state == ST_WR);
  assign slotWrite = (state == ST_WR);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

endmodule

// File: rtl/ow_branch_step.sv
module ow_branch_step
  import ow_step_pkg::*;
#(
  parameter int RD_W        = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            dirReq,
  output logic            slotReq,
  output logic            slotWrite,
  output logic            slotWrBit,
  input  logic            slotAck,
  input  logic [RD_W-1:0] slotRdData,
  output logic            busy,
  output logic            done,
  output logic [2:0]      result
);

  stepCtl_t ctl;
  logic     tmoHit;
  logic     noSlave;

  ow_step_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .slotAck   (slotAck),
    .tmoHit    (tmoHit),
    .noSlave   (noSlave),
    .ctl       (ctl),
    .slotReq   (slotReq),
    .slotWrite (slotWrite),
    .busy      (busy),
    .done      (done)
  );

  ow_step_dp #(
    .RD_W        (RD_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dirReq     (dirReq),
    .slotRdData (slotRdData),
    .tmoHit     (tmoHit),
    .noSlave    (noSlave),
    .wrBit      (slotWrBit),
    .result     (result)
  );

endmodule

// File: rtl/ow_step_chk.sv
module ow_step_chk (
  input logic       clk,
  input logic       rstN,
  input logic       slotReq,
  input logic       slotWrite,
  input logic       slotWrBit,
  input logic       slotAck,
  input logic       busy,
  input logic       done,
  input logic [2:0] result
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!slotReq && !done)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && !slotAck) |=> (slotReq || done)); // R8

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result == 3'b000 || result == 3'b010 || result == 3'b011 ||
              result == 3'b100 || result == 3'b101)); // R3

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R7

  AST_WRBIT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && slotWrite && !slotAck) |=> ($stable(slotWrBit) || done)); // R4

  AST_WRITE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && slotWrite && slotAck) |=> done); // R1

endmodule

bind ow_branch_step ow_step_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotReq   (slotReq),
  .slotWrite (slotWrite),
  .slotWrBit (slotWrBit),
  .slotAck   (slotAck),
  .busy      (busy),
  .done      (done),
  .result    (result)
);

// File: tb/tb_ow_branch_step.sv
module tb_ow_branch_step;

  localparam int RD_W = 8;
  localparam int TMO  = 16;

  logic            clk = 1'b0;
  logic            rstN;
  logic            startReq;
  logic            dirReq;
  logic            slotReq;
  logic            slotWrite;
  logic            slotWrBit;
  logic            slotAck;
  logic [RD_W-1:0] slotRdData;
  logic            busy;
  logic            done;
  logic [2:0]      result;

  always #5 clk = ~clk;

  ow_branch_step #(.RD_W(RD_W), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dirReq(dirReq),
    .slotReq(slotReq), .slotWrite(slotWrite), .slotWrBit(slotWrBit),
    .slotAck(slotAck), .slotRdData(slotRdData), .busy(busy),
    .done(done), .result(result)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // observations from the last step
  logic [2:0] obsRes;
  int obsReads, obsWrites, obsWrIdx, obsDoneW, obsTmoReq;
  bit obsWrBit, obsBusyAfter;

  // one step with a slot-engine model; tmoSlot = slot index never acknowledged
  task automatic doStep(input bit dir, input bit idB, input bit cmpB, input int lat,
                        input bit junk, input int tmoSlot, input bit overlapStart);
    int slotIdx = 0;
    int waitCnt = 0;
    bit doneSeen = 0;
    obsReads = 0; obsWrites = 0; obsWrIdx = -1; obsDoneW = 0; obsTmoReq = 0;
    obsWrBit = 0; obsBusyAfter = 0; obsRes = 3'b111;
    @(negedge clk);
    startReq = 1'b1; dirReq = dir;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      startReq = 1'b0;
      slotAck  = 1'b0;
      slotRdData = '0;
      if (overlapStart && cyc == 2) begin startReq = 1'b1; dirReq = ~dir; end
      if (doneSeen && !done) begin
        obsBusyAfter = busy;
        break;
      end
      if (done) begin
        if (!doneSeen) obsRes = result;
        doneSeen = 1;
        obsDoneW++;
        if (overlapStart) begin startReq = 1'b1; dirReq = ~dir; end
      end else if (slotReq) begin
        if (slotIdx == tmoSlot) begin
          obsTmoReq++;
        end else if (waitCnt >= lat) begin
          slotAck = 1'b1;
          if (slotWrite) begin
            obsWrites++; obsWrBit = slotWrBit; obsWrIdx = slotIdx;
          end else begin
            obsReads++;
            slotRdData = {(junk ? 7'h7F : 7'h00), (slotIdx == 0) ? idB : cmpB};
          end
          slotIdx++;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  endtask

  // vector: {dir, id, cmp, lat[3:0], junk, expRes[2:0], expWrite, expWrBit}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 3'b000, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 3'b100, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b0, 4'd2, 1'b0, 3'b101, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 4'd0, 1'b1, 3'b010, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd3, 1'b1, 3'b010, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 3'b101, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'd1, 1'b1, 3'b011, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'd5, 1'b0, 3'b011, 1'b0, 1'b0}
  };

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; dirReq = 1'b0; slotAck = 1'b0; slotRdData = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !slotReq && !done, "R9 idle after reset", busy, 0);
    check(result == 3'b011, "R9 result after reset", result, 3);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !slotReq, "R9 idle after release", slotReq, 0);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      doStep(v[12], v[11], v[10], int'(v[9:6]), v[5], -1, 1'b0);
      check(obsRes == v[4:2], "R3/R4/R2 result code", obsRes, v[4:2]);
      check(obsWrites == int'(v[1]), "R2 write slot count", obsWrites, v[1]);
      check(obsReads == 2, "R1 read slots", obsReads, 2);
      if (v[1]) begin
        check(obsWrBit == v[0], "R4 written direction", obsWrBit, v[0]);
        check(obsWrIdx == 2, "R1 write is third slot", obsWrIdx, 2);
      end
      if (v[5]) check(obsRes == v[4:2], "R5 upper read bits ignored", obsRes, v[4:2]);
      check(obsDoneW == 1, "R8 done width", obsDoneW, 1);
    end

    // R6 timeout on first read
    doStep(1'b1, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0);
    check(obsRes == 3'b011, "R6 abort result", obsRes, 3);
    check(obsTmoReq == TMO, "R6 request length", obsTmoReq, TMO);
    check(obsReads == 0 && obsWrites == 0, "R6 no further slots", obsReads + obsWrites, 0);
    check(obsDoneW == 1, "R6 done after abort", obsDoneW, 1);

    // R6 timeout on the write slot of a discrepancy
    doStep(1'b1, 1'b0, 1'b0, 0, 1'b0, 2, 1'b0);
    check(obsRes == 3'b011, "R6 write abort result", obsRes, 3);
    check(obsTmoReq == TMO, "R6 write request length", obsTmoReq, TMO);
    check(obsReads == 2 && obsWrites == 0, "R6 reads then abort", obsReads, 2);

    // R6 acknowledge in the last allowed cycle
    doStep(1'b0, 1'b1, 1'b0, TMO - 1, 1'b0, -1, 1'b0);
    check(obsRes == 3'b101, "R6 late ack accepted", obsRes, 5);
    check(obsWrites == 1, "R6 late ack write", obsWrites, 1);

    // R7 start during busy and during done with opposite direction
    doStep(1'b1, 1'b0, 1'b0, 1, 1'b0, -1, 1'b1);
    check(obsRes == 3'b100, "R7 direction kept", obsRes, 4);
    check(obsWrBit == 1'b1, "R7 written bit kept", obsWrBit, 1);
    check(!obsBusyAfter, "R7 no restart from done cycle", obsBusyAfter, 0);

    // R8 result held after done
    repeat (3) @(negedge clk);
    check(result == 3'b100 && !busy, "R8 result held while idle", result, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule